// File: doc/BRIEF.md
# Registered Inverting Bus Transceiver

This block links two 8-bit ports, A and B, and can hand data across in either direction. Each port has its own capture register with its own rising-edge clock: one register stores what arrives on port A and the other stores what arrives on port B. An active-low enable and a direction input choose which port, if any, is driven. Two select inputs decide, for each direction on its own, whether the driven port shows live data from the opposite port or that port's stored copy. Both paths invert, so the driven port always carries the complement of the chosen value.

Each port is modelled as three separate buses: an input, an output and a per-bit output enable. A pad ring would combine them into a tri-state pin. Captures are never gated by the output controls. The transceiver can therefore sample both ports while isolated, or sample the port it is driving. A synchronous active-high reset clears both registers on their own clock edges.

Top module: `inv_reg_xcvr`

## Requirements
- R1: A rising edge of either capture clock while `rst` is high clears that clock's register to all zeros. With a stored path selected and enabled, the driven port then reads all ones (8'hFF).
- R2: Every rising edge of `clkAtoB` with `rst` low stores `aIn` into the A register, and every rising edge of `clkBtoA` stores `bIn` into the B register. This happens for every value of `outEnN`, `dirToB`, `selStoredToA` and `selStoredToB`.
- R3: While `outEnN` is 1, `aOutEn` and `bOutEn` are all zeros and `aOut` and `bOut` are all zeros.
- R4: While `outEnN` is 0 and `dirToB` is 0, `aOutEn` is all ones and `bOutEn` and `bOut` are all zeros.
- R5: While `outEnN` is 0 and `dirToB` is 1, `bOutEn` is all ones and `aOutEn` and `aOut` are all zeros.
- R6: While port A is driven, `aOut` equals the bitwise complement of `bIn` when `selStoredToA` is 0, and the complement of the B register when `selStoredToA` is 1.
- R7: While port B is driven, `bOut` equals the bitwise complement of `aIn` when `selStoredToB` is 0, and the complement of the A register when `selStoredToB` is 1.
- R8: `aOutEn` and `bOutEn` are never nonzero at the same time.
- R9: The outputs and enables are combinational in the controls, the opposite port's input and the registers. A change of any select, enable or direction input shows at the outputs without a clock edge.
- R10: An edge on one capture clock leaves the other register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkAtoB | input | 1 | Rising edge captures `aIn` into the A register |
| clkBtoA | input | 1 | Rising edge captures `bIn` into the B register |
| rst | input | 1 | Synchronous active-high clear, applied on each capture clock |
| outEnN | input | 1 | Active-low output enable; high isolates both ports |
| dirToB | input | 1 | 1 drives port B, 0 drives port A |
| selStoredToB | input | 1 | 1 sends the stored A value to port B, 0 sends live `aIn` |
| selStoredToA | input | 1 | 1 sends the stored B value to port A, 0 sends live `bIn` |
| aIn | input | 8 | Value seen on port A |
| aOut | output | 8 | Value driven onto port A |
| aOutEn | output | 8 | Per-bit drive enable for port A |
| bIn | input | 8 | Value seen on port B |
| bOut | output | 8 | Value driven onto port B |
| bOutEn | output | 8 | Per-bit drive enable for port B |

## Verification
A wrong value in either capture register stays hidden until the matching stored path is selected and enabled. It then appears at once, with no clock needed, as a wrong complement on the driven port. The bench therefore reads both registers back through the stored paths after every capture, and also probes the register that was not clocked. A fault in the control decode shows up immediately as wrong enables for one of the sixteen control combinations. The bench sweeps all sixteen combinations for every data pattern.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int DEFAULT_WIDTH = 8;

  typedef struct packed {
    logic driveA;
    logic driveB;
    logic useStoredToA;
    logic useStoredToB;
  } xcvrStrobe_t;
endpackage

// File: rtl/xcvr_capreg.sv
module xcvr_capreg #(
  parameter int WIDTH = xcvr_pkg::DEFAULT_WIDTH
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  // R2: every clean edge stores the sampled input
  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (q == $past(d)));

  // R1: the edge after a reset edge sees a cleared register
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (q == '0));
endmodule

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl (
  input  logic                  outEnN,
  input  logic                  dirToB,
  input  logic                  selStoredToB,
  input  logic                  selStoredToA,
  output xcvr_pkg::xcvrStrobe_t strobe
);
  always_comb begin
    strobe.driveA       = ~outEnN & ~dirToB;
    strobe.driveB       = ~outEnN &  dirToB;
    strobe.useStoredToA = selStoredToA;
    strobe.useStoredToB = selStoredToB;
  end
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath #(
  parameter int WIDTH = xcvr_pkg::DEFAULT_WIDTH
) (
  input  logic                  clkAtoB,
  input  logic                  clkBtoA,
  input  logic                  rst,
  input  xcvr_pkg::xcvrStrobe_t strobe,
  input  logic [WIDTH-1:0]      aIn,
  input  logic [WIDTH-1:0]      bIn,
  output logic [WIDTH-1:0]      aOut,
  output logic [WIDTH-1:0]      aOutEn,
  output logic [WIDTH-1:0]      bOut,
  output logic [WIDTH-1:0]      bOutEn
);
  localparam int SIDES = 2;

  logic [WIDTH-1:0] storedA;
  logic [WIDTH-1:0] storedB;

  xcvr_capreg #(.WIDTH(WIDTH)) regA_i (
    .clk(clkAtoB), .rst(rst), .d(aIn), .q(storedA)
  );
  xcvr_capreg #(.WIDTH(WIDTH)) regB_i (
    .clk(clkBtoA), .rst(rst), .d(bIn), .q(storedB)
  );

  // index 0 feeds port A (source: B side), index 1 feeds port B (source: A side)
  logic [WIDTH-1:0] liveSrc   [SIDES];
  logic [WIDTH-1:0] storedSrc [SIDES];
  logic             useStored [SIDES];
  logic             drive     [SIDES];
  logic [WIDTH-1:0] sideOut   [SIDES];
  logic [WIDTH-1:0] sideEn    [SIDES];

  assign liveSrc[0]   = bIn;
  assign storedSrc[0] = storedB;
  assign useStored[0] = strobe.useStoredToA;
  assign drive[0]     = strobe.driveA;
  assign liveSrc[1]   = aIn;
  assign storedSrc[1] = storedA;
  assign useStored[1] = strobe.useStoredToB;
  assign drive[1]     = strobe.driveB;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    logic [WIDTH-1:0] picked;
    assign picked     = useStored[s] ? storedSrc[s] : liveSrc[s];
    assign sideOut[s] = drive[s] ? ~picked : '0;
    assign sideEn[s]  = {WIDTH{drive[s]}};
  end

  assign aOut   = sideOut[0];
  assign aOutEn = sideEn[0];
  assign bOut   = sideOut[1];
  assign bOutEn = sideEn[1];

  // R8: the two ports never drive together
  always_comb begin
    if (!$isunknown({aOutEn, bOutEn}))
      p_one_driver_r8: assert (!((|aOutEn) && (|bOutEn)));
  end
endmodule

// File: rtl/inv_reg_xcvr.sv
module inv_reg_xcvr (
  input  logic       clkAtoB,
  input  logic       clkBtoA,
  input  logic       rst,
  input  logic       outEnN,
  input  logic       dirToB,
  input  logic       selStoredToB,
  input  logic       selStoredToA,
  input  logic [7:0] aIn,
  output logic [7:0] aOut,
  output logic [7:0] aOutEn,
  input  logic [7:0] bIn,
  output logic [7:0] bOut,
  output logic [7:0] bOutEn
);
  localparam int WIDTH = 8;

  xcvr_pkg::xcvrStrobe_t strobe;

  xcvr_ctrl ctrl_i (
    .outEnN(outEnN), .dirToB(dirToB),
    .selStoredToB(selStoredToB), .selStoredToA(selStoredToA),
    .strobe(strobe)
  );

  xcvr_datapath #(.WIDTH(WIDTH)) dp_i (
    .clkAtoB(clkAtoB), .clkBtoA(clkBtoA), .rst(rst), .strobe(strobe),
    .aIn(aIn), .bIn(bIn),
    .aOut(aOut), .aOutEn(aOutEn), .bOut(bOut), .bOutEn(bOutEn)
  );

  // R3: a high enable input leaves both ports undriven
  always_comb begin
    if (!$isunknown({outEnN, aOutEn, bOutEn}) && outEnN)
      p_isolate_r3: assert (aOutEn == '0 && bOutEn == '0);
  end
endmodule

// File: tb/inv_reg_xcvr_tb_top.sv
module inv_reg_xcvr_tb_top;
  localparam int W = 8;

  logic clk = 0;
  logic clkAtoB = 0, clkBtoA = 0, rst = 0;
  logic outEnN = 1, dirToB = 0, selStoredToB = 0, selStoredToA = 0;
  logic [W-1:0] aIn = '0, bIn = '0;
  logic [W-1:0] aOut, aOutEn, bOut, bOutEn;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] stA, stB;

  always #2 clk = ~clk;

  inv_reg_xcvr dut_i (
    .clkAtoB(clkAtoB), .clkBtoA(clkBtoA), .rst(rst), .outEnN(outEnN),
    .dirToB(dirToB), .selStoredToB(selStoredToB), .selStoredToA(selStoredToA),
    .aIn(aIn), .aOut(aOut), .aOutEn(aOutEn),
    .bIn(bIn), .bOut(bOut), .bOutEn(bOutEn)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setCtrl(input logic [3:0] c);
    {outEnN, dirToB, selStoredToB, selStoredToA} = c;
  endtask

  task automatic pulse(input bit doA, input bit doB);
    #1;
    if (doA) clkAtoB = 1;
    if (doB) clkBtoA = 1;
    #2;
    clkAtoB = 0;
    clkBtoA = 0;
    #1;
    if (doA) stA = rst ? '0 : aIn;
    if (doB) stB = rst ? '0 : bIn;
  endtask

  // R9: sampled after input changes only, no clock edge between
  task automatic checkAll();
    logic enA, enB;
    logic [W-1:0] expA, expB;
    string enTag;
    #1;
    enA = !outEnN && !dirToB;
    enB = !outEnN && dirToB;
    expA = enA ? ~(selStoredToA ? stB : bIn) : '0;
    expB = enB ? ~(selStoredToB ? stA : aIn) : '0;
    enTag = outEnN ? "R3" : (dirToB ? "R5" : "R4");
    chk(enTag, aOutEn, {W{enA}});
    chk(enTag, bOutEn, {W{enB}});
    chk(enA ? "R6" : enTag, aOut, expA);
    chk(enB ? "R7" : enTag, bOut, expB);
    chk("R8", {7'd0, (|aOutEn) && (|bOutEn)}, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R1: reset clears both registers
    aIn = 8'h5A; bIn = 8'hC3;
    rst = 1;
    pulse(1, 1);
    rst = 0;
    setCtrl(4'b1000);
    checkAll();
    setCtrl(4'b0001);
    #1 chk("R1", aOut, 8'hFF);
    setCtrl(4'b0110);
    #1 chk("R1", bOut, 8'hFF);

    for (int i = 0; i < 14; i++) begin
      logic bitA, bitB;
      aIn = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : W'(i * 37 + 5);
      bIn = (i == 0) ? 8'hFF : (i == 1) ? 8'h00 : W'(i * 91 + 200);
      for (int c = 0; c < 16; c++) begin
        setCtrl(4'(c));
        checkAll();
      end
      // R2: capture under an arbitrary mode, including while driving
      setCtrl(4'(i));
      aIn = W'(i * 53 + 17);
      bIn = ~W'(i * 29);
      bitA = (i % 3) != 1;
      bitB = (i % 3) != 0;
      pulse(bitA, bitB);
      checkAll();
      aIn = ~aIn; bIn = ~bIn;
      setCtrl(4'b0001);
      #1 chk(bitB ? "R2" : "R10", aOut, ~stB);
      setCtrl(4'b0110);
      #1 chk(bitA ? "R2" : "R10", bOut, ~stA);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule